// File: doc/BRIEF.md
# Tone Gate and Timer Status Glue

This block sits between a parallel output byte written by the processor, the third channel of an interval timer, and a one-bit sound transducer. Each write to the output byte is latched in full, and the stored copy is offered to other read paths. Two bits of the stored byte have fixed meanings. The lowest bit drives the gate input of timer channel 2. The next bit lets the timer's square wave through to the transducer.

The transducer level is the AND of that enable bit and the timer output. It is produced by a flop, so it changes one clock after either term changes and does not glitch when both change in the same cycle. A status byte is read back on a parallel input port and carries two views of the timer output. Bit 5 takes a fresh sample of the timer output on every read. Bit 4 takes a fresh sample only on reads made while the stored gate bit is 1, and otherwise keeps its last value. Software can therefore tell the live level from a level frozen while the gate was off.

Top module: `tone_gate_glue`

## Requirements
- R1: While reset is held and after it is released, the stored output byte is 0x00, the gate output is 0, the transducer level is 0 and the status byte is 0x00.
- R2: A write strobe stores the whole data byte at that clock edge. The stored byte appears on `pb_q`, and `gate_o` equals its bit 0.
- R3: Bit 1 of the stored byte is the transducer enable. After each clock edge, `spk_o` equals the enable being stored at that edge ANDed with `tmr_out` sampled at that edge.
- R4: On every status read, bit 5 of the status byte is loaded with `tmr_out` as sampled at that clock edge.
- R5: On a status read, bit 4 is loaded with `tmr_out` only if bit 0 of the stored byte is 1. Otherwise bit 4 keeps its previous value.
- R6: When a write and a status read fall in the same cycle, R5 uses bit 0 of the byte stored before that write.
- R7: Without a read strobe, the status byte does not change, whatever `tmr_out` or the written byte does.
- R8: Status bits other than 4 and 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pb_wr | input | 1 | Write strobe for the output byte, one cycle per write |
| pb_data | input | 8 | Data byte to be written |
| tmr_out | input | 1 | Output level of timer channel 2 |
| pc_rd | input | 1 | Status read strobe, one cycle per read |
| pb_q | output | 8 | Stored output byte |
| gate_o | output | 1 | Gate input for timer channel 2 |
| spk_o | output | 1 | Registered transducer level |
| pc_stat | output | 8 | Status byte with the timer-output bits |

## Verification
The properties assume that `pb_wr`, `pb_data`, `pc_rd` and `tmr_out` are synchronous to `clk` and are defined from the first edge. They are written against the internally synchronised reset, so they say nothing about the two cycles in which that reset is still being released. The stimulus changes every input only on the falling clock edge. It issues no write or read until several cycles after reset is released, and it includes a cycle with a write and a read together so that the ordering rule is exercised.

// File: rtl/tgg_pkg.sv
package tgg_pkg;
  // Control bits decoded from the stored output byte
  typedef struct packed {
    logic gate;
    logic spk_en;
  } tgg_ctl_t;
endpackage

// File: rtl/tgg_rst_sync.sv
module tgg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tgg_portb_reg.sv
module tgg_portb_reg
  import tgg_pkg::*;
#(
  parameter int DW       = 8,
  parameter int GATE_BIT = 0,
  parameter int SPK_BIT  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] byte_q,
  output tgg_ctl_t      ctl_q,
  output tgg_ctl_t      ctl_next
);
  logic [DW-1:0] byte_d;

  always_comb begin
    byte_d = byte_q;
    if (wr_en) byte_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_q <= '0;
    else        byte_q <= byte_d;
  end

  always_comb begin
    ctl_q.gate      = byte_q[GATE_BIT];
    ctl_q.spk_en    = byte_q[SPK_BIT];
    ctl_next.gate   = byte_d[GATE_BIT];
    ctl_next.spk_en = byte_d[SPK_BIT];
  end
endmodule

// File: rtl/tgg_spk_drv.sv
module tgg_spk_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic en_next,
  input  logic tmr_lvl,
  output logic spk_q
);
  logic spk_d;

  always_comb begin
    spk_d = en_next & tmr_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spk_q <= 1'b0;
    else        spk_q <= spk_d;
  end
endmodule

// File: rtl/tgg_stat_reg.sv
module tgg_stat_reg #(
  parameter int DW        = 8,
  parameter int FREE_BIT  = 5,
  parameter int GATED_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          gate_cur,
  input  logic          tmr_lvl,
  output logic [DW-1:0] stat_q
);
  logic [DW-1:0] stat_d;
  logic [DW-1:0] load_en;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == FREE_BIT) begin : g_free
      always_comb load_en[i] = rd_en;
    end else if (i == GATED_BIT) begin : g_gated
      always_comb load_en[i] = rd_en & gate_cur;
    end else begin : g_fixed
      always_comb load_en[i] = 1'b0;
    end
    always_comb stat_d[i] = load_en[i] ? tmr_lvl : stat_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/tone_gate_glue.sv
module tone_gate_glue
  import tgg_pkg::*;
#(
  parameter int DW        = 8,
  parameter int GATE_BIT  = 0,
  parameter int SPK_BIT   = 1,
  parameter int GATED_BIT = 4,
  parameter int FREE_BIT  = 5,
  parameter int SYNC_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pb_wr,
  input  logic [DW-1:0] pb_data,
  input  logic          tmr_out,
  input  logic          pc_rd,
  output logic [DW-1:0] pb_q,
  output logic          gate_o,
  output logic          spk_o,
  output logic [DW-1:0] pc_stat
);
  logic     rst_sync_n;
  tgg_ctl_t ctl_q;
  tgg_ctl_t ctl_next;

  tgg_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tgg_portb_reg #(.DW(DW), .GATE_BIT(GATE_BIT), .SPK_BIT(SPK_BIT)) u_pb (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(pb_wr), .wr_data(pb_data),
    .byte_q(pb_q), .ctl_q(ctl_q), .ctl_next(ctl_next)
  );

  tgg_spk_drv u_spk (
    .clk(clk), .rst_n(rst_sync_n), .en_next(ctl_next.spk_en),
    .tmr_lvl(tmr_out), .spk_q(spk_o)
  );

  tgg_stat_reg #(.DW(DW), .FREE_BIT(FREE_BIT), .GATED_BIT(GATED_BIT)) u_stat (
    .clk(clk), .rst_n(rst_sync_n), .rd_en(pc_rd), .gate_cur(ctl_q.gate),
    .tmr_lvl(tmr_out), .stat_q(pc_stat)
  );

  assign gate_o = ctl_q.gate;
endmodule

// File: rtl/tone_gate_glue_chk.sv
module tone_gate_glue_chk #(
  parameter int DW        = 8,
  parameter int GATE_BIT  = 0,
  parameter int SPK_BIT   = 1,
  parameter int GATED_BIT = 4,
  parameter int FREE_BIT  = 5
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          pb_wr,
  input logic [DW-1:0] pb_data,
  input logic          tmr_out,
  input logic          pc_rd,
  input logic [DW-1:0] pb_q,
  input logic          gate_o,
  input logic          spk_o,
  input logic [DW-1:0] pc_stat
);
  localparam logic [DW-1:0] LIVE_MASK = (DW'(1) << GATED_BIT) | (DW'(1) << FREE_BIT);

  a_r2_gate_follows_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pb_wr |=> (gate_o == $past(pb_data[GATE_BIT])) && (pb_q == $past(pb_data)));

  a_r3_spk_needs_enable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    spk_o |-> pb_q[SPK_BIT]);

  a_r3_spk_rise_needs_timer: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pb_wr && !pb_q[SPK_BIT] |=> !spk_o);

  a_r4_free_bit_sampled: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc_rd |=> pc_stat[FREE_BIT] == $past(tmr_out));

  a_r5_gated_bit_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_rd && !gate_o) |=> $stable(pc_stat[GATED_BIT]));

  a_r5_gated_bit_sampled: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_rd && gate_o) |=> pc_stat[GATED_BIT] == $past(tmr_out));

  a_r7_no_read_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pc_rd |=> $stable(pc_stat));

  a_r8_other_bits_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_stat & ~LIVE_MASK) == '0);
endmodule

bind tone_gate_glue tone_gate_glue_chk #(
  .DW(DW), .GATE_BIT(GATE_BIT), .SPK_BIT(SPK_BIT),
  .GATED_BIT(GATED_BIT), .FREE_BIT(FREE_BIT)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .pb_wr(pb_wr), .pb_data(pb_data),
  .tmr_out(tmr_out), .pc_rd(pc_rd), .pb_q(pb_q), .gate_o(gate_o),
  .spk_o(spk_o), .pc_stat(pc_stat)
);

// File: tb/sim_tone_gate_glue.sv
module sim_tone_gate_glue;
  logic       clk;
  logic       rst_n;
  logic       pb_wr;
  logic [7:0] pb_data;
  logic       tmr_out;
  logic       pc_rd;
  logic [7:0] pb_q;
  logic       gate_o;
  logic       spk_o;
  logic [7:0] pc_stat;

  int n_run;
  int n_fail;

  tone_gate_glue u0 (
    .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_data(pb_data),
    .tmr_out(tmr_out), .pc_rd(pc_rd), .pb_q(pb_q), .gate_o(gate_o),
    .spk_o(spk_o), .pc_stat(pc_stat)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Entry: [28] wr, [27:20] data, [19] timer, [18] read,
  //        [17] exp gate, [16] exp spk, [15:8] exp status, [7:0] exp stored byte
  localparam int NV = 12;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 8'h03, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h03}, // R2 R3 write enable+gate
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h03}, // R3 R4 R5 timer low
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h30, 8'h03}, // R4 R5 timer high
    {1'b1, 8'h02, 1'b1, 1'b0, 1'b0, 1'b1, 8'h30, 8'h02}, // R2 gate off
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 8'h02}, // R5 hold bit 4
    {1'b1, 8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h10, 8'h01}, // R3 enable off
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h01}, // R4 R5 gated sample
    {1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h30, 8'h00}, // R6 same-cycle write+read
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 8'h00}, // R5 hold after write
    {1'b1, 8'hFE, 1'b1, 1'b0, 1'b0, 1'b1, 8'h10, 8'hFE}, // R2 R8 all high but bit 0
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h30, 8'hFE}, // R4 R8
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h30, 8'hFE}  // R7 no read, R3 timer drop
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "stored byte", pb_q, 8'h00);
    check(req, "gate", {7'd0, gate_o}, 8'h00);
    check(req, "speaker", {7'd0, spk_o}, 8'h00);
    check(req, "status", pc_stat, 8'h00);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; pb_wr = 1'b0; pb_data = 8'h00; tmr_out = 1'b1; pc_rd = 1'b0;
    repeat (3) @(posedge clk);
    #2 check_idle("R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pb_wr   = VEC[i][28];
      pb_data = VEC[i][27:20];
      tmr_out = VEC[i][19];
      pc_rd   = VEC[i][18];
      @(posedge clk);
      #2;
      pb_wr = 1'b0; pc_rd = 1'b0;
      check("R2", "stored byte", pb_q, VEC[i][7:0]);
      check("R2", "gate", {7'd0, gate_o}, {7'd0, VEC[i][17]});
      check("R3", "speaker", {7'd0, spk_o}, {7'd0, VEC[i][16]});
      check("R4/R5", "status", pc_stat, VEC[i][15:8]);
    end

    // R7: timer toggles and a write with no read leave status untouched
    @(negedge clk) pb_wr = 1'b1; pb_data = 8'h03; tmr_out = 1'b0;
    @(negedge clk) pb_wr = 1'b0; tmr_out = 1'b1;
    @(negedge clk);
    check("R7", "status", pc_stat, 8'h30);
    check("R3", "speaker", {7'd0, spk_o}, 8'h01);

    // R1: reset in mid-run clears everything
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule